// File: doc/BRIEF.md
# Two-Channel Signal Power Monitor

This block measures two streams of signed converter samples over a programmable window of clock cycles and reports one 20-bit figure per channel at the end of each window. The figure depends on the selected mode. In power mode it is the mean-square value or its integer square root (rms). In peak mode it is the largest magnitude seen. In crossing mode it is the number of samples whose magnitude reaches a programmable threshold. A complex option treats channel A as I and channel B as Q. In that case both channels report the power of I² + Q².

The controls are sampled only when a window starts, so software may rewrite them at any time without corrupting the window in progress. Samples count only in cycles where the valid strobe is high. Both results load together at the end of a window, and a one-cycle done strobe marks the update. Dropping the enable abandons the current window and freezes the results.

Top module: `sigmon_top`

## Requirements
- R1: While enabled, a window lasts L clock cycles, where L is the window length. The first window starts on the clock edge that sees the enable rise, and its samples are taken in the L following cycles. `res_done` is high in the cycle after the last of these and never earlier.
- R2: The window length L is the period input, except that any period below 128 (including 0) gives L = 128.
- R3: Mode 00 with `ms_sel` = 1 reports the sum over the window of mag² for each channel, shifted right by ceil(log2 L), and saturated at 1048575. Here mag is |sample|, with -8192 taken as 8191.
- R4: Mode 00 with `ms_sel` = 0 reports floor(sqrt()) of the same shifted mean-square value.
- R5: Mode 01 reports the largest mag among the window's valid samples.
- R6: Modes 10 and 11 both report the count of valid samples whose mag is greater than or equal to `thresh`.
- R7: When `cplx_en` = 1 in mode 00, the power summed for both channels is mag_A² + mag_B² per sample. Both results then carry the same value.
- R8: While `mon_en` = 0, no window runs, `res_done` stays low and the results hold. After a window is abandoned, a re-enabled window counts only its own samples.
- R9: Mode, rms/ms select, complex enable, threshold and period are captured when a window starts. A change during a window first affects the next one, and consecutive windows follow each other with no gap cycle.
- R10: After reset both results are 0 and `res_done` is low. `res_done` is a single-cycle pulse. Samples with `smp_valid` = 0 contribute nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Monitor enable |
| mode_sel | input | 2 | 00 power, 01 peak, 10/11 threshold crossing |
| ms_sel | input | 1 | 1 mean-square, 0 rms (power mode) |
| cplx_en | input | 1 | Combine A (I) and B (Q) into complex power |
| period | input | 24 | Window length in clock cycles (minimum 128) |
| thresh | input | 13 | Magnitude threshold for crossing mode |
| smp_valid | input | 1 | Sample strobe for both channels |
| smp_a | input | 14 | Channel A sample, two's complement |
| smp_b | input | 14 | Channel B sample, two's complement |
| res_a | output | 20 | Channel A result |
| res_b | output | 20 | Channel B result |
| res_done | output | 1 | One-cycle pulse when the results update |

## Verification
Each mode is exercised with constant, sign-alternating and ramping sample streams. Constants give a closed-form power and count. Alternating signs show that magnitude, not signed value, is squared and compared. Ramps make the peak land on one particular sample. Channel B always receives a different stream from channel A so that a channel swap shows up. The complex case makes both results equal to a sum that neither channel gives alone. Full-scale and most-negative inputs exercise the ms saturation and the magnitude clamp. Half-rate valid strobes halve the counts. Periods of 0, 100, 128, 130, 200 and 256 cover the minimum clamp and a non-power-of-two shift. A mid-window change of mode, threshold and period is followed by a second back-to-back window.

// File: rtl/sigmon_pkg.sv
package sigmon_pkg;

  typedef enum logic [1:0] {
    MODE_POWER     = 2'b00,
    MODE_PEAK      = 2'b01,
    MODE_CROSS     = 2'b10,
    MODE_CROSS_ALT = 2'b11
  } mode_e;

  // Smallest s with 2**s >= v.
  function automatic logic [5:0] clog2_up(input logic [31:0] v);
    logic [5:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if ((32'd1 << i) < v) r = 6'(i + 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/sigmon_window.sv
module sigmon_window
  import sigmon_pkg::*;
#(
  parameter int PERIOD_W = 24,
  parameter int MIN_LEN  = 128,
  parameter int MAG_W    = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mon_en,
  input  logic [PERIOD_W-1:0] period_i,
  input  mode_e               mode_i,
  input  logic                ms_i,
  input  logic                cplx_i,
  input  logic [MAG_W-1:0]    thr_i,
  output logic                active_o,
  output logic                win_end_o,
  output logic                clr_o,
  output mode_e               mode_q,
  output logic                ms_q,
  output logic                cplx_q,
  output logic [5:0]          shift_q,
  output logic [MAG_W-1:0]    thr_q
);

  localparam logic [PERIOD_W-1:0] MIN_L = PERIOD_W'(MIN_LEN);
  localparam logic [PERIOD_W-1:0] ONE   = PERIOD_W'(1);

  logic [PERIOD_W-1:0] len_in, len_q, cnt_q;
  logic                load;

  assign len_in    = (period_i < MIN_L) ? MIN_L : period_i;
  assign win_end_o = active_o && mon_en && (cnt_q == len_q - ONE);
  assign load      = mon_en && (!active_o || win_end_o);
  assign clr_o     = !mon_en || load;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
      len_q    <= MIN_L;
      mode_q   <= MODE_POWER;
      ms_q     <= 1'b0;
      cplx_q   <= 1'b0;
      shift_q  <= '0;
      thr_q    <= '0;
    end else if (!mon_en) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (load) begin
      active_o <= 1'b1;
      cnt_q    <= '0;
      len_q    <= len_in;
      mode_q   <= mode_i;
      ms_q     <= ms_i;
      cplx_q   <= cplx_i;
      shift_q  <= clog2_up(32'(len_in));
      thr_q    <= thr_i;
    end else if (active_o) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  // R1
  cnt_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    active_o |-> (cnt_q < len_q));

  // R2
  min_len_chk: assert property (@(posedge clk) disable iff (rst)
    len_q >= MIN_L);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active_o && mon_en && !win_end_o) |=> ($stable(len_q) && $stable(mode_q) && $stable(thr_q)));

endmodule

// File: rtl/sigmon_chan_acc.sv
module sigmon_chan_acc #(
  parameter int SAMPLE_W = 14,
  parameter int MAG_W    = 13,
  parameter int ACC_W    = 51,
  parameter int RES_W    = 20
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       take,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic [MAG_W-1:0]           thr_i,
  output logic [ACC_W-1:0]           sum_nx,
  output logic [MAG_W-1:0]           peak_nx,
  output logic [RES_W-1:0]           hits_nx
);

  localparam int SQ_W = 2 * MAG_W;
  localparam logic [SAMPLE_W-1:0] MAG_CAP = SAMPLE_W'((1 << MAG_W) - 1);

  logic [SAMPLE_W-1:0] raw, abs_v;
  logic [MAG_W-1:0]    mag;
  logic [SQ_W-1:0]     sq;
  logic [ACC_W-1:0]    sum_q;
  logic [MAG_W-1:0]    peak_q;
  logic [RES_W-1:0]    hits_q;

  always_comb begin
    raw     = smp_i;
    abs_v   = raw[SAMPLE_W-1] ? (~raw + SAMPLE_W'(1)) : raw;
    mag     = (abs_v > MAG_CAP) ? MAG_W'(MAG_CAP) : abs_v[MAG_W-1:0];
    sq      = {{MAG_W{1'b0}}, mag} * {{MAG_W{1'b0}}, mag};
    sum_nx  = sum_q + (take ? ACC_W'(sq) : '0);
    peak_nx = (take && (mag > peak_q)) ? mag : peak_q;
    hits_nx = (take && (mag >= thr_i) && !(&hits_q)) ? hits_q + RES_W'(1) : hits_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sum_q  <= '0;
      peak_q <= '0;
      hits_q <= '0;
    end else begin
      sum_q  <= sum_nx;
      peak_q <= peak_nx;
      hits_q <= hits_nx;
    end
  end

  // R5
  peak_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (peak_q >= $past(peak_q)));

  // R6
  hits_step_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((hits_q == $past(hits_q)) || (hits_q == $past(hits_q) + RES_W'(1))));

  // R10
  idle_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !take) |=> $stable(sum_q));

endmodule

// File: rtl/sigmon_reduce.sv
module sigmon_reduce
  import sigmon_pkg::*;
#(
  parameter int ACC_W = 51,
  parameter int MAG_W = 13,
  parameter int RES_W = 20
) (
  input  mode_e            mode_i,
  input  logic             ms_i,
  input  logic [5:0]       shift_i,
  input  logic [ACC_W-1:0] pwr_i,
  input  logic [MAG_W-1:0] peak_i,
  input  logic [RES_W-1:0] hits_i,
  output logic [RES_W-1:0] res_o
);

  localparam int MEAN_W = 2 * MAG_W + 1;
  localparam int RT_W   = (MEAN_W + 1) / 2;
  localparam logic [MEAN_W-1:0] RES_CAP = MEAN_W'((1 << RES_W) - 1);

  function automatic logic [RT_W-1:0] isqrt(input logic [MEAN_W-1:0] v);
    logic [RT_W-1:0]   r;
    logic [2*RT_W-1:0] t;
    r = '0;
    for (int i = RT_W - 1; i >= 0; i--) begin
      r[i] = 1'b1;
      t    = {{RT_W{1'b0}}, r} * {{RT_W{1'b0}}, r};
      if (t > (2*RT_W)'(v)) r[i] = 1'b0;
    end
    return r;
  endfunction

  logic [ACC_W-1:0]  shifted;
  logic [MEAN_W-1:0] mean;
  logic [RES_W-1:0]  ms_val;
  logic [RT_W-1:0]   root;

  always_comb begin
    shifted = pwr_i >> shift_i;
    mean    = (|shifted[ACC_W-1:MEAN_W]) ? '1 : shifted[MEAN_W-1:0];
    ms_val  = (mean > RES_CAP) ? RES_W'(RES_CAP) : RES_W'(mean);
    root    = isqrt(mean);
    case (mode_i)
      MODE_POWER: res_o = ms_i ? ms_val : RES_W'(root);
      MODE_PEAK:  res_o = RES_W'(peak_i);
      default:    res_o = hits_i;
    endcase
  end

endmodule

// File: rtl/sigmon_top.sv
module sigmon_top
  import sigmon_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int MAG_W    = 13,
  parameter int RES_W    = 20,
  parameter int PERIOD_W = 24,
  parameter int MIN_LEN  = 128
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mon_en,
  input  logic [1:0]                 mode_sel,
  input  logic                       ms_sel,
  input  logic                       cplx_en,
  input  logic [PERIOD_W-1:0]        period,
  input  logic [MAG_W-1:0]           thresh,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_a,
  input  logic signed [SAMPLE_W-1:0] smp_b,
  output logic [RES_W-1:0]           res_a,
  output logic [RES_W-1:0]           res_b,
  output logic                       res_done
);

  localparam int N_CH  = 2;
  localparam int ACC_W = 2 * MAG_W + 1 + PERIOD_W;
  localparam logic [RES_W-1:0] PEAK_CAP = RES_W'((1 << MAG_W) - 1);

  logic             active, win_end, clr, ms_q, cplx_q;
  mode_e            mode_q;
  logic [5:0]       shift_q;
  logic [MAG_W-1:0] thr_q;
  logic             done_q;

  logic signed [SAMPLE_W-1:0] smp     [N_CH];
  logic [ACC_W-1:0]           sum_nx  [N_CH];
  logic [RES_W-1:0]           res_nx  [N_CH];
  logic [RES_W-1:0]           res_q   [N_CH];
  logic [ACC_W-1:0]           pwr_cplx;

  assign smp[0]   = smp_a;
  assign smp[1]   = smp_b;
  assign pwr_cplx = sum_nx[0] + sum_nx[1];

  sigmon_window #(
    .PERIOD_W(PERIOD_W), .MIN_LEN(MIN_LEN), .MAG_W(MAG_W)
  ) u_window (
    .clk(clk), .rst(rst), .mon_en(mon_en), .period_i(period),
    .mode_i(mode_e'(mode_sel)), .ms_i(ms_sel), .cplx_i(cplx_en), .thr_i(thresh),
    .active_o(active), .win_end_o(win_end), .clr_o(clr),
    .mode_q(mode_q), .ms_q(ms_q), .cplx_q(cplx_q), .shift_q(shift_q), .thr_q(thr_q)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [MAG_W-1:0] peak_nx;
    logic [RES_W-1:0] hits_nx;
    logic [ACC_W-1:0] pwr;

    sigmon_chan_acc #(
      .SAMPLE_W(SAMPLE_W), .MAG_W(MAG_W), .ACC_W(ACC_W), .RES_W(RES_W)
    ) u_acc (
      .clk(clk), .rst(rst), .clr(clr), .take(active && smp_valid),
      .smp_i(smp[c]), .thr_i(thr_q),
      .sum_nx(sum_nx[c]), .peak_nx(peak_nx), .hits_nx(hits_nx)
    );

    assign pwr = cplx_q ? pwr_cplx : sum_nx[c];

    sigmon_reduce #(
      .ACC_W(ACC_W), .MAG_W(MAG_W), .RES_W(RES_W)
    ) u_reduce (
      .mode_i(mode_q), .ms_i(ms_q), .shift_i(shift_q), .pwr_i(pwr),
      .peak_i(peak_nx), .hits_i(hits_nx), .res_o(res_nx[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      for (int c = 0; c < N_CH; c++) res_q[c] <= '0;
    end else begin
      done_q <= win_end;
      if (win_end) begin
        for (int c = 0; c < N_CH; c++) res_q[c] <= res_nx[c];
      end
    end
  end

  assign res_a    = res_q[0];
  assign res_b    = res_q[1];
  assign res_done = done_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mon_en |=> (!done_q && $stable(res_q[0]) && $stable(res_q[1])));

  // R5
  peak_range_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && ($past(mode_q) == MODE_PEAK)) |-> ((res_q[0] <= PEAK_CAP) && (res_q[1] <= PEAK_CAP)));

endmodule

// File: tb/sigmon_top_tb_top.sv
module sigmon_top_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst = 1'b1;
  logic               mon_en = 1'b0;
  logic [1:0]         mode_sel = 2'b00;
  logic               ms_sel = 1'b0;
  logic               cplx_en = 1'b0;
  logic [23:0]        period = 24'd128;
  logic [12:0]        thresh = 13'd0;
  logic               smp_valid = 1'b0;
  logic signed [13:0] smp_a = '0;
  logic signed [13:0] smp_b = '0;
  logic [19:0]        res_a, res_b;
  logic               res_done;

  sigmon_top dut_i (
    .clk(clk), .rst(rst), .mon_en(mon_en), .mode_sel(mode_sel), .ms_sel(ms_sel),
    .cplx_en(cplx_en), .period(period), .thresh(thresh), .smp_valid(smp_valid),
    .smp_a(smp_a), .smp_b(smp_b), .res_a(res_a), .res_b(res_b), .res_done(res_done)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint mag_of(input int x);
    int m;
    m = (x < 0) ? -x : x;
    return (m > 8191) ? 8191 : m;
  endfunction

  function automatic int shift_of(input int len);
    int s;
    s = 0;
    while ((1 << s) < len) s++;
    return s;
  endfunction

  function automatic longint root_of(input longint v);
    longint lo, hi, mid;
    lo = 0; hi = 20000;
    while (lo < hi) begin
      mid = (lo + hi + 1) / 2;
      if (mid * mid <= v) lo = mid; else hi = mid - 1;
    end
    return lo;
  endfunction

  function automatic int stim(input int pat, input int k, input int amp);
    case (pat)
      0:       return amp;
      1:       return (k % 2 == 1) ? -amp : amp;
      default: return amp - 23 * k;
    endcase
  endfunction

  function automatic longint exp_res(input int mode, input bit ms, input bit cx, input int len,
                                     input longint own, input longint other,
                                     input longint pk, input longint ct);
    longint p, m;
    if (mode == 0) begin
      p = cx ? own + other : own;
      m = p >> shift_of(len);
      if (ms) return (m > 1048575) ? 1048575 : m;
      return root_of(m);
    end
    if (mode == 1) return pk;
    return ct;
  endfunction

  typedef struct packed {
    logic [1:0]         mode;
    logic               ms;
    logic               cx;
    logic               vh;
    logic [1:0]         pat;
    logic [11:0]        per;
    logic [12:0]        thr;
    logic signed [13:0] a;
    logic signed [13:0] b;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 12'd128, 13'd0,    14'sd100,   -14'sd200},
    '{2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 12'd200, 13'd0,    14'sd1000,  -14'sd3000},
    '{2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 12'd0,   13'd0,    14'sd8191,  14'sd20},
    '{2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 12'd150, 13'd0,    14'sd4000,  -14'sd4000},
    '{2'd2, 1'b0, 1'b0, 1'b1, 2'd1, 12'd100, 13'd500,  14'sd600,   14'sd400},
    '{2'd3, 1'b0, 1'b0, 1'b0, 2'd2, 12'd130, 13'd1000, 14'sd3000,  14'sd100},
    '{2'd0, 1'b1, 1'b1, 1'b0, 2'd0, 12'd128, 13'd0,    14'sd300,   14'sd400},
    '{2'd0, 1'b0, 1'b1, 1'b1, 2'd1, 12'd256, 13'd0,    -14'sd1234, 14'sd2345},
    '{2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 12'd100, 13'd0,    -14'sd8192, 14'sd8191},
    '{2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 12'd128, 13'd0,    -14'sd8192, -14'sd1}
  };

  bit          chg_pending = 1'b0;
  logic [1:0]  chg_mode;
  logic [23:0] chg_per;
  logic [12:0] chg_thr;

  // Drives one window starting at the current negedge; returns at the negedge
  // where the done pulse for it should be visible.
  task automatic drive_window(input int len, input int pat, input int amp_a, input int amp_b,
                              input bit vh,
                              output longint sa, output longint sb, output longint pa,
                              output longint pb, output longint ca, output longint cb);
    bit  early;
    int  x, y, thr_l;
    bit  v;
    longint ma, mb;
    early = 1'b0;
    thr_l = int'(thresh);
    sa = 0; sb = 0; pa = 0; pb = 0; ca = 0; cb = 0;
    for (int k = 0; k < len; k++) begin
      x = stim(pat, k, amp_a);
      y = stim(pat, k, amp_b);
      v = vh ? (k % 2 == 0) : 1'b1;
      smp_a = 14'(x);
      smp_b = 14'(y);
      smp_valid = v;
      if (v) begin
        ma = mag_of(x); mb = mag_of(y);
        sa += ma * ma; sb += mb * mb;
        if (ma > pa) pa = ma;
        if (mb > pb) pb = mb;
        if (ma >= thr_l) ca++;
        if (mb >= thr_l) cb++;
      end
      if (chg_pending && k == len / 2) begin
        mode_sel = chg_mode; period = chg_per; thresh = chg_thr;
        chg_pending = 1'b0;
      end
      @(negedge clk);
      if (k < len - 1 && res_done) early = 1'b1;
    end
    smp_valid = 1'b0;
    chk("R1", longint'(early), 0);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1: watchdog expired, actual 1 expected 0");
    report();
    $finish;
  end

  initial begin
    longint sa, sb, pa, pb, ca, cb;
    longint hold_a, hold_b, ea, eb;
    vec_t   vv;
    int     len;
    string  tg;
    bit     seen;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk("R10", res_a, 0);
    chk("R10", res_b, 0);
    chk("R10", res_done, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      vv = VECS[i];
      mon_en   = 1'b0;
      mode_sel = vv.mode;
      ms_sel   = vv.ms;
      cplx_en  = vv.cx;
      period   = 24'(vv.per);
      thresh   = vv.thr;
      @(negedge clk);
      mon_en = 1'b1;
      @(negedge clk);
      len = (vv.per < 128) ? 128 : int'(vv.per);
      drive_window(len, int'(vv.pat), int'(vv.a), int'(vv.b), vv.vh, sa, sb, pa, pb, ca, cb);
      chk((vv.per < 128) ? "R2" : "R1", res_done, 1);
      if (vv.mode == 2'd0 && vv.cx) tg = "R7";
      else if (vv.mode == 2'd0 && vv.ms) tg = "R3";
      else if (vv.mode == 2'd0) tg = "R4";
      else if (vv.mode == 2'd1) tg = "R5";
      else tg = "R6";
      ea = exp_res(int'(vv.mode), vv.ms, vv.cx, len, sa, sb, pa, ca);
      eb = exp_res(int'(vv.mode), vv.ms, vv.cx, len, sb, sa, pb, cb);
      chk(vv.vh ? "R10" : tg, res_a, ea);
      chk(tg, res_b, eb);
      mon_en = 1'b0;
      @(negedge clk);
      // R10: the done strobe lasts one cycle
      chk("R10", res_done, 0);
    end

    // R8: disabled monitor ignores samples, raises no done, holds results
    hold_a = res_a;
    hold_b = res_b;
    seen   = 1'b0;
    mode_sel = 2'd0; ms_sel = 1'b1; cplx_en = 1'b0; period = 24'd128; thresh = 13'd0;
    for (int k = 0; k < 300; k++) begin
      smp_a = 14'sd8000; smp_b = -14'sd8000; smp_valid = 1'b1;
      @(negedge clk);
      if (res_done) seen = 1'b1;
    end
    chk("R8", seen, 0);
    chk("R8", res_a, hold_a);
    chk("R8", res_b, hold_b);

    // R8: abandoned window leaves nothing behind
    mon_en = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 60; k++) begin
      smp_a = 14'sd8000; smp_b = 14'sd7000; smp_valid = 1'b1;
      @(negedge clk);
    end
    mon_en = 1'b0;
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", res_done, 0);
    mon_en = 1'b1;
    @(negedge clk);
    drive_window(128, 0, 50, -70, 1'b0, sa, sb, pa, pb, ca, cb);
    chk("R8", res_done, 1);
    chk("R8", res_a, 2500);
    chk("R8", res_b, 4900);
    mon_en = 1'b0;
    @(negedge clk);

    // R9: mid-window change of mode, period and threshold
    mode_sel = 2'd1; ms_sel = 1'b0; cplx_en = 1'b0; period = 24'd128; thresh = 13'd5000;
    chg_mode = 2'd2; chg_per = 24'd200; chg_thr = 13'd0; chg_pending = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
    @(negedge clk);
    drive_window(128, 0, 700, -900, 1'b0, sa, sb, pa, pb, ca, cb);
    chk("R9", res_done, 1);
    chk("R9", res_a, 700);
    chk("R9", res_b, 900);
    drive_window(200, 0, 700, -900, 1'b0, sa, sb, pa, pb, ca, cb);
    chk("R9", res_done, 1);
    chk("R9", res_a, 200);
    chk("R9", res_b, 200);
    mon_en = 1'b0;
    @(negedge clk);

    report();
    $finish;
  end

endmodule